// File: doc/BRIEF.md
# Serial sync/data delay generator

This block produces the transmit timing of a synchronous serial port: a serial clock, a frame-sync strobe and a serial data line carrying one parallel word. It runs from an internal clock at twice the bit rate, so every bit clock period is two internal cycles. Software loads a 32-bit mode word through a one-cycle write strobe. That word gives the delay from sync assertion to the first data bit (setup), the delay from the last data bit to sync negation (hold), the sync polarity, the bit order and an idle interval that follows each frame.

Both delays can be set in half-bit-clock steps. Each is a 3-bit code. The mode word is checked when it is written. If either code is undefined, or if the two delays together are not a whole number of bit clocks, both delays fall back to zero. A start pulse latches the word and the decoded mode, and the frame then runs on its own. A one-cycle done pulse marks the end of the frame.

Timing convention: a tick is one internal clock cycle. Tick j of a frame appears on the outputs after the (j+2)-th rising edge, counting as the first the edge at which start is sampled high. Let D and H be the setup and hold delays in half-bit units, W the word width and G the idle interval. The frame ends at tick T = D + 2W + H + 2G.

Top module: `sdly_tx`

## Requirements
- R1: After reset, fsync, sclk, sdo and done are all 0.
- R2: Delay codes decode to half-bit units as 000=0, 001=2, 010=4, 101=1, 110=3, and 011=6 for the hold field only. These fallbacks set both D and H to 0: setup code 011, 100 or 111; hold code 100 or 111; or D+H odd.
- R3: The setup code sits at mode bits 22:20 and the hold code at bits 18:16. Sync is active from tick 0 through tick D+2W+H-1 and inactive otherwise.
- R4: Data bit n is driven on sdo during ticks D+2n and D+2n+1, for n = 0 to W-1. At all other ticks sdo is 0.
- R5: sclk is 1 exactly at ticks D+2n+1 (the second half of each data bit) and 0 at all other times.
- R6: done is 1 for exactly one cycle, at tick T, with sync already inactive.
- R7: Mode bit 25 selects the sync level: with 0, active is 1 and idle is 0; with 1, active is 0 and idle is 1. The idle level holds between frames.
- R8: Mode bit 24 selects the bit order: with 0, data bit n is word bit W-1-n (MSB first); with 1, it is word bit n (LSB first).
- R9: The 2-bit idle interval field at mode bits 3:2 adds 2G ticks between sync negation and done.
- R10: A start pulse while a frame is running is ignored: the running frame is unchanged and its word is not replaced.
- R11: A mode write during a frame does not change that frame. The next frame uses the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mode word write strobe |
| cfg_wdata | input | 32 | Mode word |
| start | input | 1 | Frame start pulse, accepted when idle |
| tx_word | input | DATA_W | Parallel word sampled at start |
| sclk | output | 1 | Serial clock |
| fsync | output | 1 | Frame sync |
| sdo | output | 1 | Serial data |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The hardest case is the fallback for an odd delay sum. Both codes are legal on their own, so it shows only as shifted sync and data edges, not as any flag. The stimulus walks every setup/hold code pair, including the undefined codes. For each pair it computes the expected tick of every sync, clock and data edge. Illegal pairs must land exactly on the zero-delay positions. Separate frames raise start and write a new mode partway through a running frame. A frame then runs without a rewrite, to show that the pending mode is taken up only at the next start.

// File: rtl/sdly_pkg.sv
package sdly_pkg;

  localparam int SETUP_LSB = 20;
  localparam int HOLD_LSB  = 16;
  localparam int POL_BIT   = 25;
  localparam int ORDER_BIT = 24;
  localparam int GAP_LSB   = 2;
  localparam int CODE_W    = 3;
  localparam int HALF_W    = 3;
  localparam int GAP_W     = 2;

  typedef struct packed {
    logic [HALF_W-1:0] setup_half;
    logic [HALF_W-1:0] hold_half;
    logic              pol_low;
    logic              lsb_first;
    logic [GAP_W-1:0]  gap;
  } mode_t;

  // returns {legal, half-bit count}
  function automatic logic [HALF_W:0] code_to_half(input logic [CODE_W-1:0] c,
                                                    input logic hold_side);
    logic [HALF_W:0] r;
    case (c)
      3'b000:  r = {1'b1, 3'd0};
      3'b001:  r = {1'b1, 3'd2};
      3'b010:  r = {1'b1, 3'd4};
      3'b011:  r = hold_side ? {1'b1, 3'd6} : {1'b0, 3'd0};
      3'b101:  r = {1'b1, 3'd1};
      3'b110:  r = {1'b1, 3'd3};
      default: r = {1'b0, 3'd0};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sdly_cfg.sv
module sdly_cfg
  import sdly_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [31:0] wdata,
  output mode_t       mode
);

  logic [HALF_W:0] su_dec;
  logic [HALF_W:0] ho_dec;
  logic            pair_ok;
  mode_t           mode_n;

  always_comb begin
    su_dec  = code_to_half(wdata[SETUP_LSB +: CODE_W], 1'b0);
    ho_dec  = code_to_half(wdata[HOLD_LSB +: CODE_W], 1'b1);
    pair_ok = su_dec[HALF_W] && ho_dec[HALF_W] &&
              !(su_dec[0] ^ ho_dec[0]);
    mode_n.setup_half = pair_ok ? su_dec[HALF_W-1:0] : '0;
    mode_n.hold_half  = pair_ok ? ho_dec[HALF_W-1:0] : '0;
    mode_n.pol_low    = wdata[POL_BIT];
    mode_n.lsb_first  = wdata[ORDER_BIT];
    mode_n.gap        = wdata[GAP_LSB +: GAP_W];
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= '0;
    else if (we) mode <= mode_n;
  end

endmodule

// File: rtl/sdly_seq.sv
module sdly_seq
  import sdly_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  mode_t mode,
  output logic load,
  output logic run,
  output logic win,
  output logic half_odd,
  output logic frm_pol,
  output logic [HALF_W-1:0] frm_setup,
  output logic fsync,
  output logic sclk,
  output logic done
);

  logic [CNT_W-1:0]  cnt;
  logic [HALF_W-1:0] frm_hold;
  logic [GAP_W-1:0]  frm_gap;
  logic [CNT_W-1:0]  data_lo, data_hi, sync_end, t_end, kk;
  logic              sync_act;

  assign load = start && !run;

  always_comb begin
    data_lo  = CNT_W'(frm_setup);
    data_hi  = data_lo + CNT_W'(2 * DATA_W);
    sync_end = data_hi + CNT_W'(frm_hold);
    t_end    = sync_end + CNT_W'({frm_gap, 1'b0});
    kk       = cnt - data_lo;
    sync_act = run && (cnt < sync_end);
    win      = run && (cnt >= data_lo) && (cnt < data_hi);
    half_odd = kk[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      cnt       <= '0;
      frm_setup <= '0;
      frm_hold  <= '0;
      frm_gap   <= '0;
      frm_pol   <= 1'b0;
    end else if (load) begin
      run       <= 1'b1;
      cnt       <= '0;
      frm_setup <= mode.setup_half;
      frm_hold  <= mode.hold_half;
      frm_gap   <= mode.gap;
      frm_pol   <= mode.pol_low;
    end else if (run) begin
      if (cnt == t_end) run <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsync <= 1'b0;
      sclk  <= 1'b0;
      done  <= 1'b0;
    end else begin
      fsync <= sync_act ^ frm_pol;
      sclk  <= win && half_odd;
      done  <= run && (cnt == t_end);
    end
  end

endmodule

// File: rtl/sdly_shift.sv
module sdly_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              lsb_first,
  input  logic [DATA_W-1:0] word,
  input  logic              win,
  input  logic              half_odd,
  output logic              sdo
);

  logic [DATA_W-1:0] sh;
  logic              lsb_q;
  logic              cur_bit;

  assign cur_bit = lsb_q ? sh[0] : sh[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      lsb_q <= 1'b0;
    end else if (load) begin
      sh    <= word;
      lsb_q <= lsb_first;
    end else if (win && half_odd) begin
      if (lsb_q) sh <= {1'b0, sh[DATA_W-1:1]};
      else       sh <= {sh[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sdo <= 1'b0;
    else     sdo <= win ? cur_bit : 1'b0;
  end

endmodule

// File: rtl/sdly_tx.sv
module sdly_tx
  import sdly_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  output logic              sclk,
  output logic              fsync,
  output logic              sdo,
  output logic              done
);

  localparam int T_MAX = 4 + 2 * DATA_W + 6 + 6;
  localparam int CNT_W = $clog2(T_MAX + 1) + 1;

  mode_t             mode;
  logic              load, run, win, half_odd, frm_pol;
  logic [HALF_W-1:0] frm_setup;
  logic [HALF_W-1:0] cfg_setup_half, cfg_hold_half;

  assign cfg_setup_half = mode.setup_half;
  assign cfg_hold_half  = mode.hold_half;

  sdly_cfg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .mode(mode)
  );

  sdly_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .load(load), .run(run), .win(win), .half_odd(half_odd),
    .frm_pol(frm_pol), .frm_setup(frm_setup),
    .fsync(fsync), .sclk(sclk), .done(done)
  );

  sdly_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .lsb_first(mode.lsb_first),
    .word(tx_word), .win(win), .half_odd(half_odd), .sdo(sdo)
  );

endmodule

// File: rtl/sdly_tx_chk.sv
module sdly_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       sclk,
  input logic       fsync,
  input logic       done,
  input logic       run,
  input logic       frm_pol,
  input logic [2:0] frm_setup,
  input logic [2:0] cfg_setup_half,
  input logic [2:0] cfg_hold_half
);

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_sync_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (fsync == frm_pol));

  a_r5_sclk_one_tick: assert property (@(posedge clk) disable iff (rst)
    sclk |=> !sclk);

  a_r5_sclk_inside_sync: assert property (@(posedge clk) disable iff (rst)
    sclk |-> (fsync != frm_pol));

  a_r2_sum_whole: assert property (@(posedge clk) disable iff (rst)
    !(cfg_setup_half[0] ^ cfg_hold_half[0]));

  a_r2_setup_max: assert property (@(posedge clk) disable iff (rst)
    cfg_setup_half <= 3'd4);

  a_r10_busy_start: assert property (@(posedge clk) disable iff (rst)
    (run && start) |=> $stable(frm_setup));

endmodule

bind sdly_tx sdly_tx_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .sclk(sclk), .fsync(fsync),
  .done(done), .run(run), .frm_pol(frm_pol), .frm_setup(frm_setup),
  .cfg_setup_half(cfg_setup_half), .cfg_hold_half(cfg_hold_half)
);

// File: tb/sdly_tx_test.sv
`timescale 1ns/1ps
module sdly_tx_test;

  localparam int W = 8;
  localparam real HALF_PER = 10.0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [31:0]  cfg_wdata = '0;
  logic         start = 1'b0;
  logic [W-1:0] tx_word = '0;
  logic         sclk, fsync, sdo, done;

  always #(HALF_PER) clk = ~clk;

  sdly_tx #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .start(start), .tx_word(tx_word),
    .sclk(sclk), .fsync(fsync), .sdo(sdo), .done(done)
  );

  typedef struct {
    logic  fs, sc, sd, dn;
    string tag;
  } item_t;

  item_t q[$];
  int    vectors = 0;
  int    miscompares = 0;
  bit    finished = 0;

  function automatic int half_of(input int c, input bit hold, output bit ok);
    ok = 1;
    case (c)
      0: return 0;
      1: return 2;
      2: return 4;
      3: begin if (hold) return 6; ok = 0; return 0; end
      5: return 1;
      6: return 3;
      default: begin ok = 0; return 0; end
    endcase
  endfunction

  function automatic void chk(input logic act, input logic exp, input string what,
                              input string req, input string tag);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s (frame %s): got %0b expected %0b at %0t",
               req, what, tag, act, exp, $time);
    end
  endfunction

  // monitor: compare one expected item per cycle, between edges
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      vectors++;
      chk(fsync, it.fs, "fsync", "R3", it.tag);
      chk(sclk,  it.sc, "sclk",  "R5", it.tag);
      chk(sdo,   it.sd, "sdo",   "R4", it.tag);
      chk(done,  it.dn, "done",  "R6", it.tag);
    end
  end

  logic [2:0] pend_su, pend_ho;
  logic       pend_pol, pend_lsb;
  logic [1:0] pend_gap;

  task automatic write_mode(input int su, input int ho, input bit pol,
                            input bit lsb, input int gap);
    @(posedge clk); #1;
    cfg_wdata = '0;
    cfg_wdata[22:20] = 3'(su);
    cfg_wdata[18:16] = 3'(ho);
    cfg_wdata[25] = pol;
    cfg_wdata[24] = lsb;
    cfg_wdata[3:2] = 2'(gap);
    cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    pend_su = 3'(su); pend_ho = 3'(ho); pend_pol = pol;
    pend_lsb = lsb; pend_gap = 2'(gap);
  endtask

  // mid: 0 none, 1 start pulse while busy (R10), 2 mode write while busy (R11)
  task automatic run_frame(input logic [W-1:0] word, input string tag, input int mid);
    int  d, h, t;
    bit  ok1, ok2;
    d = half_of(int'(pend_su), 0, ok1);
    h = half_of(int'(pend_ho), 1, ok2);
    if (!ok1 || !ok2 || ((d + h) % 2 != 0)) begin d = 0; h = 0; end  // R2
    t = d + 2 * W + h + 2 * int'(pend_gap);                           // R9
    @(posedge clk); #1;
    tx_word = word; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; tx_word = ~word;
    @(posedge clk); #1;
    for (int j = 0; j <= t + 2; j++) begin
      item_t it;
      logic  act, wn, bitv;
      int    k, n;
      act = (j < d + 2 * W + h);
      wn  = (j >= d) && (j < d + 2 * W);
      k   = j - d;
      n   = k / 2;
      bitv = 1'b0;
      if (wn) bitv = pend_lsb ? word[n] : word[W - 1 - n];            // R8
      it.fs = act ^ pend_pol;                                         // R7
      it.sc = wn && (k % 2 == 1);
      it.sd = bitv;
      it.dn = (j == t);
      it.tag = tag;
      q.push_back(it);
    end
    if (mid == 1) begin
      repeat (3) @(posedge clk);
      #1; tx_word = 8'h0F; start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
    end else if (mid == 2) begin
      logic [2:0] s_su, s_ho; logic s_pol, s_lsb; logic [1:0] s_gap;
      s_su = pend_su; s_ho = pend_ho; s_pol = pend_pol; s_lsb = pend_lsb; s_gap = pend_gap;
      repeat (2) @(posedge clk);
      write_mode(1, 1, ~s_pol, ~s_lsb, 2);
      pend_su = 3'd1; pend_ho = 3'd1;
      if (s_su == 3'd1) pend_su = 3'd1;
      pend_gap = 2'd2;
      if (s_gap == 2'd2) pend_gap = 2'd2;
    end
    wait (q.size() == 0);
    @(posedge clk); #1;
  endtask

  initial begin
    #(HALF_PER * 2.0 * 200000.0);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    pend_su = 0; pend_ho = 0; pend_pol = 0; pend_lsb = 0; pend_gap = 0;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    vectors++;
    if ({fsync, sclk, sdo, done} !== 4'b0000) begin
      miscompares++;
      $display("FAIL R1 reset outputs: got %b expected 0000", {fsync, sclk, sdo, done});
    end

    // R2/R3: every legal and illegal setup/hold code pair, idle interval 1
    for (int su = 0; su < 8; su++) begin
      for (int ho = 0; ho < 8; ho++) begin
        write_mode(su, ho, 0, 0, 1);
        run_frame(8'hA5 ^ 8'(su * 8 + ho), "R2_R3_pair", 0);
      end
    end

    // R7: active-low sync, R8: LSB first
    write_mode(5, 1, 1, 0, 1);
    run_frame(8'h3C, "R7", 0);
    write_mode(2, 6, 0, 1, 1);
    run_frame(8'h81, "R8", 0);
    write_mode(6, 3, 1, 1, 0);
    run_frame(8'hC6, "R7_R8", 0);

    // R9: idle interval values
    for (int g = 0; g < 4; g++) begin
      write_mode(1, 2, 0, 0, g);
      run_frame(8'h5A, "R9", 0);
    end

    // R10: start while busy ignored
    write_mode(2, 2, 0, 0, 1);
    run_frame(8'hF0, "R10", 1);

    // R11: mode written during a frame takes effect on the next one only
    write_mode(0, 0, 0, 0, 0);
    run_frame(8'h96, "R11_current", 2);
    run_frame(8'h69, "R11_next", 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule